// File: doc/BRIEF.md
# Host Data-Bus Buffer for a Slave Peripheral Controller

This block is the host-facing side of a slave peripheral controller. A master processor reaches it over an 8-bit three-state bus with active-low chip select, read and write strobes and one address line. Host writes fill an input buffer. The address line that goes with each write is kept as a data/command tag. Host reads return either the output buffer or an 8-bit status byte, depending on the address line.

The local processor sees a simple register port. It can read the input buffer, and a one-cycle pulse tells the block that the byte has been consumed. It can write the output buffer and the upper status nibble, and it can raise a DMA request. Host strobes are asynchronous to the local clock. They pass through a parameterised synchroniser, and each flag changes once, at the end of each strobe. Three optional port pins can carry the output-full flag, the input-full flag and the DMA request in place of ordinary port data. An active-low DMA acknowledge input, when enabled, turns a host strobe into a data access without chip select.

Top module: `hdbb_top`

## Requirements
- R1: `dq_oe` is 1 only while `rd_n` is low and the block is selected (`cs_n` low, or DMA enabled with `dack_n` low). It is 0 during writes and while idle.
- R2: During a selected host read, `dq_o` is the output buffer when the effective address is 0 and the status byte when it is 1. The status byte has OBF at bit 0, IBF at bit 1, the user flag at bit 2, the command tag at bit 3 and the local nibble at bits 7:4.
- R3: A selected host write loads the input buffer, seen on `loc_ibuf_q`. It sets IBF and stores the effective address in status bit 3. The update happens once, within SYNC_STAGES+2 clock cycles after the strobe is released.
- R4: A `loc_ibuf_rd` pulse clears IBF. If it lands in the same cycle as a host write update, IBF stays set.
- R5: A `loc_obuf_wr` pulse loads the output buffer from `loc_wdata` and sets OBF. A host read at address 0 clears OBF when the strobe ends. A host read at address 1 leaves OBF unchanged.
- R6: A `loc_sts_wr` pulse copies `loc_wdata[7:4]` into status bits 7:4 and leaves status bits 3:0 unchanged.
- R7: `port_q[0]`, `port_q[1]` and `port_q[2]` show OBF, IBF and the DMA request when `cfg_obf_pin`, `cfg_ibf_pin` and `cfg_dma_en` are set. When the enable for a pin is clear, that pin shows the matching bit of `port_d`.
- R8: With `cfg_dma_en` set, a strobe made while `dack_n` is low acts as a selected access at address 0, whatever the state of `cs_n` and `a0`. With `cfg_dma_en` clear, `dack_n` has no effect.
- R9: A `loc_drq_set` pulse raises the DMA request. The falling edge of `dack_n` clears it, but only while `cfg_dma_en` is set.
- R10: Reset clears both buffers, OBF, IBF, the command tag, the status nibble and the DMA request.
- R11: Status bit 2 follows the `loc_uflag` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Host address: 0 data, 1 command/status |
| dack_n | input | 1 | DMA acknowledge, active low |
| dq_i | input | DW | Host bus, inbound |
| dq_o | output | DW | Host bus, outbound |
| dq_oe | output | 1 | Host bus drive enable |
| loc_ibuf_rd | input | 1 | Local pulse: input buffer consumed |
| loc_ibuf_q | output | DW | Input buffer contents |
| loc_obuf_wr | input | 1 | Local pulse: load output buffer |
| loc_sts_wr | input | 1 | Local pulse: load status upper nibble |
| loc_wdata | input | DW | Local write data |
| loc_uflag | input | 1 | User flag shown in status bit 2 |
| loc_drq_set | input | 1 | Local pulse: raise DMA request |
| cfg_obf_pin | input | 1 | Route OBF to port_q[0] |
| cfg_ibf_pin | input | 1 | Route IBF to port_q[1] |
| cfg_dma_en | input | 1 | Enable DMA: request on port_q[2], honour dack_n |
| port_d | input | 3 | Ordinary port data for the three pins |
| port_q | output | 3 | Port pin values |

## Verification
The hardest case to reach from the ports is a host write update landing in the same local clock cycle as a `loc_ibuf_rd` pulse, because the host write event appears only after the synchroniser. The bench releases the write strobe on a falling clock edge. It counts SYNC_STAGES falling edges and raises the consume pulse exactly over the update edge, then repeats the test one cycle later. It expects IBF to stay set the first time and to be cleared the second time. Full sweeps of all 256 byte values in both directions, of all status nibble and user-flag values, and of all pin-enable and port-data combinations cover the rest.

// File: rtl/hdbb_pkg.sv
package hdbb_pkg;
   // status bit positions (host software decodes these)
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_USR = 2;
   localparam int ST_CMD = 3;
   localparam int ST_HI  = 4;

   // port pin slots
   localparam int PIN_OBF = 0;
   localparam int PIN_IBF = 1;
   localparam int PIN_DRQ = 2;
   localparam int NPINS   = 3;

   // host control bundle, active high after inversion
   typedef struct packed {
      logic cs;
      logic rd;
      logic wr;
      logic a0;
      logic dack;
   } hctl_t;

   localparam int HCTL_W = $bits(hctl_t);
endpackage

// File: rtl/hdbb_sync.sv
module hdbb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar g = 0; g < STAGES; g++) begin : g_stg
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stg[g-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/hdbb_host_evt.sv
module hdbb_host_evt
   import hdbb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  hctl_t         ctl,
   input  logic [DW-1:0] d,
   input  logic          dma_en,
   output logic          wr_evt,
   output logic          wr_a0,
   output logic [DW-1:0] wr_d,
   output logic          rd_evt,
   output logic          rd_a0,
   output logic          dack_evt
);
   logic dack_on, sel, a0_eff, rd_on, wr_on;
   logic rd_q, wr_q, dack_q;

   assign dack_on = dma_en & ctl.dack;
   assign sel     = ctl.cs | dack_on;
   assign a0_eff  = ctl.a0 & ~dack_on;
   assign rd_on   = sel & ctl.rd;
   assign wr_on   = sel & ctl.wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
         dack_q <= 1'b0;
         wr_a0  <= 1'b0;
         rd_a0  <= 1'b0;
         wr_d   <= '0;
      end else begin
         rd_q   <= rd_on;
         wr_q   <= wr_on;
         dack_q <= dack_on;
         if (wr_on) begin
            wr_d  <= d;
            wr_a0 <= a0_eff;
         end
         if (rd_on) rd_a0 <= a0_eff;
      end
   end

   // one event per strobe, at its trailing edge
   assign wr_evt   = wr_q & ~wr_on;
   assign rd_evt   = rd_q & ~rd_on;
   assign dack_evt = dack_on & ~dack_q;
endmodule

// File: rtl/hdbb_regs.sv
module hdbb_regs
   import hdbb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_evt,
   input  logic               wr_a0,
   input  logic [DW-1:0]      wr_d,
   input  logic               rd_evt,
   input  logic               rd_a0,
   input  logic               dack_evt,
   input  logic               loc_ibuf_rd,
   input  logic               loc_obuf_wr,
   input  logic               loc_sts_wr,
   input  logic               loc_drq_set,
   input  logic [DW-1:0]      loc_wdata,
   output logic [DW-1:0]      ibuf,
   output logic [DW-1:0]      obuf,
   output logic               ibf,
   output logic               obf,
   output logic               cmd,
   output logic [DW-ST_HI-1:0] sts_hi,
   output logic               drq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibuf   <= '0;
         obuf   <= '0;
         ibf    <= 1'b0;
         obf    <= 1'b0;
         cmd    <= 1'b0;
         sts_hi <= '0;
         drq    <= 1'b0;
      end else begin
         // input side: new host byte wins over local consume
         if (wr_evt) begin
            ibuf <= wr_d;
            cmd  <= wr_a0;
            ibf  <= 1'b1;
         end else if (loc_ibuf_rd) begin
            ibf  <= 1'b0;
         end
         // output side: new local byte wins over host drain
         if (loc_obuf_wr) begin
            obuf <= loc_wdata;
            obf  <= 1'b1;
         end else if (rd_evt && !rd_a0) begin
            obf  <= 1'b0;
         end
         if (loc_sts_wr) sts_hi <= loc_wdata[DW-1:ST_HI];
         if (loc_drq_set)   drq <= 1'b1;
         else if (dack_evt) drq <= 1'b0;
      end
   end
endmodule

// File: rtl/hdbb_pins.sv
module hdbb_pins #(
   parameter int NP     = 3,
   parameter bit MUX_EN = 1'b1
) (
   input  logic [NP-1:0] flag,
   input  logic [NP-1:0] en,
   input  logic [NP-1:0] port_d,
   output logic [NP-1:0] port_q
);
   if (MUX_EN) begin : g_mux
      for (genvar g = 0; g < NP; g++) begin : g_pin
         assign port_q[g] = en[g] ? flag[g] : port_d[g];
      end
   end else begin : g_plain
      logic [NP-1:0] unused_w;
      assign unused_w = flag & en;
      assign port_q   = port_d;
   end
endmodule

// File: rtl/hdbb_top.sv
module hdbb_top
   import hdbb_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_MUX     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          a0,
   input  logic          dack_n,
   input  logic [DW-1:0] dq_i,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe,
   input  logic          loc_ibuf_rd,
   output logic [DW-1:0] loc_ibuf_q,
   input  logic          loc_obuf_wr,
   input  logic          loc_sts_wr,
   input  logic [DW-1:0] loc_wdata,
   input  logic          loc_uflag,
   input  logic          loc_drq_set,
   input  logic          cfg_obf_pin,
   input  logic          cfg_ibf_pin,
   input  logic          cfg_dma_en,
   input  logic [2:0]    port_d,
   output logic [2:0]    port_q
);
   localparam int HI_W   = DW - ST_HI;
   localparam int SYNC_W = HCTL_W + DW;

   if (DW < ST_HI + 1) begin : g_bad_dw
      $error("hdbb_top: DW must leave room for the status nibble");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hdbb_top: SYNC_STAGES must be at least 2");
   end

   hctl_t             raw_ctl, syn_ctl;
   logic [DW-1:0]     syn_d;
   logic [SYNC_W-1:0] sync_out;

   assign raw_ctl.cs   = ~cs_n;
   assign raw_ctl.rd   = ~rd_n;
   assign raw_ctl.wr   = ~wr_n;
   assign raw_ctl.a0   = a0;
   assign raw_ctl.dack = ~dack_n;

   hdbb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({raw_ctl, dq_i}),
      .q   (sync_out)
   );
   assign {syn_ctl, syn_d} = sync_out;

   logic          wr_evt, wr_a0, rd_evt, rd_a0, dack_evt;
   logic [DW-1:0] wr_d;

   hdbb_host_evt #(.DW(DW)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (syn_ctl),
      .d        (syn_d),
      .dma_en   (cfg_dma_en),
      .wr_evt   (wr_evt),
      .wr_a0    (wr_a0),
      .wr_d     (wr_d),
      .rd_evt   (rd_evt),
      .rd_a0    (rd_a0),
      .dack_evt (dack_evt)
   );

   logic [DW-1:0]   ibuf, obuf;
   logic            ibf, obf, cmd, drq;
   logic [HI_W-1:0] sts_hi;

   hdbb_regs #(.DW(DW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_evt      (wr_evt),
      .wr_a0       (wr_a0),
      .wr_d        (wr_d),
      .rd_evt      (rd_evt),
      .rd_a0       (rd_a0),
      .dack_evt    (dack_evt),
      .loc_ibuf_rd (loc_ibuf_rd),
      .loc_obuf_wr (loc_obuf_wr),
      .loc_sts_wr  (loc_sts_wr),
      .loc_drq_set (loc_drq_set),
      .loc_wdata   (loc_wdata),
      .ibuf        (ibuf),
      .obuf        (obuf),
      .ibf         (ibf),
      .obf         (obf),
      .cmd         (cmd),
      .sts_hi      (sts_hi),
      .drq         (drq)
   );

   // host read path straight from the pins
   logic          raw_dack, host_sel, host_a0;
   logic [DW-1:0] sts;

   assign sts      = {sts_hi, cmd, loc_uflag, ibf, obf};
   assign raw_dack = cfg_dma_en & ~dack_n;
   assign host_sel = ~cs_n | raw_dack;
   assign host_a0  = a0 & ~raw_dack;
   assign dq_oe    = host_sel & ~rd_n;
   assign dq_o     = host_a0 ? sts : obuf;
   assign loc_ibuf_q = ibuf;

   logic [NPINS-1:0] pin_flag, pin_en;
   assign pin_flag[PIN_OBF] = obf;
   assign pin_flag[PIN_IBF] = ibf;
   assign pin_flag[PIN_DRQ] = drq;
   assign pin_en[PIN_OBF]   = cfg_obf_pin;
   assign pin_en[PIN_IBF]   = cfg_ibf_pin;
   assign pin_en[PIN_DRQ]   = cfg_dma_en;

   hdbb_pins #(.NP(NPINS), .MUX_EN(PIN_MUX)) u_pins (
      .flag   (pin_flag),
      .en     (pin_en),
      .port_d (port_d),
      .port_q (port_q)
   );
endmodule

// File: rtl/hdbb_chk.sv
module hdbb_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          rd_n,
   input logic          dack_n,
   input logic          cfg_dma_en,
   input logic          dq_oe,
   input logic          wr_evt,
   input logic          dack_evt,
   input logic          loc_ibuf_rd,
   input logic          loc_obuf_wr,
   input logic          loc_sts_wr,
   input logic          loc_drq_set,
   input logic [DW-1:0] loc_wdata,
   input logic          ibf,
   input logic          obf,
   input logic          drq,
   input logic [DW-5:0] sts_hi
);
   // R1
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !dq_oe);
   // R1
   oe_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && (dack_n || !cfg_dma_en)) |-> !dq_oe);
   // R3
   ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> ibf);
   // R3
   ibf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |-> $past(wr_evt));
   // R4
   ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_ibuf_rd && !wr_evt) |=> !ibf);
   // R5
   obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_obuf_wr |=> obf);
   // R6
   sts_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_sts_wr |=> (sts_hi == $past(loc_wdata[DW-1:4])));
   // R9
   drq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_drq_set |=> drq);
   // R9
   drq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dack_evt && !loc_drq_set) |=> !drq);
endmodule

bind hdbb_top hdbb_chk #(.DW(DW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .rd_n        (rd_n),
   .dack_n      (dack_n),
   .cfg_dma_en  (cfg_dma_en),
   .dq_oe       (dq_oe),
   .wr_evt      (wr_evt),
   .dack_evt    (dack_evt),
   .loc_ibuf_rd (loc_ibuf_rd),
   .loc_obuf_wr (loc_obuf_wr),
   .loc_sts_wr  (loc_sts_wr),
   .loc_drq_set (loc_drq_set),
   .loc_wdata   (loc_wdata),
   .ibf         (ibf),
   .obf         (obf),
   .drq         (drq),
   .sts_hi      (sts_hi)
);

// File: tb/hdbb_top_tb_top.sv
module hdbb_top_tb_top;
   localparam int CLK_P = 10;
   localparam int SYNC  = 2;

   logic       clk = 1'b0;
   logic       rst_n, cs_n, rd_n, wr_n, a0, dack_n;
   logic [7:0] dq_i, dq_o, loc_ibuf_q, loc_wdata;
   logic       dq_oe;
   logic       loc_ibuf_rd, loc_obuf_wr, loc_sts_wr, loc_uflag, loc_drq_set;
   logic       cfg_obf_pin, cfg_ibf_pin, cfg_dma_en;
   logic [2:0] port_d, port_q;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model of the block state
   logic       m_ibf, m_obf, m_cmd, m_drq;
   logic [3:0] m_hi;
   logic [7:0] m_ibuf;
   logic [7:0] q;
   logic       oe;

   always #(CLK_P/2) clk = ~clk;

   hdbb_top #(.DW(8), .SYNC_STAGES(SYNC), .PIN_MUX(1'b1)) dut_i (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
      .a0 (a0), .dack_n (dack_n), .dq_i (dq_i), .dq_o (dq_o), .dq_oe (dq_oe),
      .loc_ibuf_rd (loc_ibuf_rd), .loc_ibuf_q (loc_ibuf_q),
      .loc_obuf_wr (loc_obuf_wr), .loc_sts_wr (loc_sts_wr),
      .loc_wdata (loc_wdata), .loc_uflag (loc_uflag),
      .loc_drq_set (loc_drq_set), .cfg_obf_pin (cfg_obf_pin),
      .cfg_ibf_pin (cfg_ibf_pin), .cfg_dma_en (cfg_dma_en),
      .port_d (port_d), .port_q (port_q)
   );

   function automatic logic [7:0] exp_sts();
      return {m_hi, m_cmd, loc_uflag, m_ibf, m_obf};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one host strobe; race_off>0 pulses loc_ibuf_rd that many falling edges after release
   task automatic host_cyc(input bit is_wr, input bit via_dack, input bit av,
                           input logic [7:0] d, input int race_off,
                           output logic [7:0] rq, output logic roe);
      @(negedge clk);
      cs_n = via_dack; dack_n = !via_dack; a0 = av; dq_i = d;
      @(negedge clk);
      if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
      @(negedge clk);
      rq = dq_o; roe = dq_oe;
      repeat (3) @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         loc_ibuf_rd = (k + 1 == race_off);
         if (k == 1) begin cs_n = 1'b1; dack_n = 1'b1; end
      end
      loc_ibuf_rd = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic hrd(input bit av);
      host_cyc(1'b0, 1'b0, av, 8'h00, 0, q, oe);
   endtask

   task automatic hwr(input bit av, input logic [7:0] d);
      host_cyc(1'b1, 1'b0, av, d, 0, q, oe);
   endtask

   task automatic l_rd();
      @(negedge clk); loc_ibuf_rd = 1'b1;
      @(negedge clk); loc_ibuf_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic l_obuf(input logic [7:0] d);
      @(negedge clk); loc_wdata = d; loc_obuf_wr = 1'b1;
      @(negedge clk); loc_obuf_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic l_sts(input logic [7:0] d);
      @(negedge clk); loc_wdata = d; loc_sts_wr = 1'b1;
      @(negedge clk); loc_sts_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic l_drq();
      @(negedge clk); loc_drq_set = 1'b1;
      @(negedge clk); loc_drq_set = 1'b0;
      @(negedge clk);
   endtask

   task automatic pin_sweep(input string tag);
      for (int c = 0; c < 64; c++) begin
         logic [2:0] en, pd, flg, ex;
         en = c[2:0]; pd = c[5:3];
         flg = {m_drq, m_ibf, m_obf};
         @(negedge clk);
         {cfg_dma_en, cfg_ibf_pin, cfg_obf_pin} = en;
         port_d = pd;
         @(negedge clk);
         ex = (en & flg) | (~en & pd);
         chk(tag, port_q, ex);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_ibf = 0; m_obf = 0; m_cmd = 0; m_drq = 0; m_hi = 0; m_ibuf = 0;
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      cs_n = 1; rd_n = 1; wr_n = 1; a0 = 0; dack_n = 1; dq_i = 0;
      loc_ibuf_rd = 0; loc_obuf_wr = 0; loc_sts_wr = 0; loc_wdata = 0;
      loc_uflag = 0; loc_drq_set = 0;
      cfg_obf_pin = 1; cfg_ibf_pin = 1; cfg_dma_en = 1; port_d = 3'b000;
      do_reset();

      // R10: state after reset
      hrd(1'b1);
      chk("R10 status after reset", q, 8'h00);
      chk("R1 oe during status read", oe, 1'b1);
      chk("R10 ibuf after reset", loc_ibuf_q, 8'h00);
      chk("R10 pins after reset", port_q, 3'b000);

      // R1: unselected read, selected idle, write
      @(negedge clk); rd_n = 1'b0;
      @(negedge clk); chk("R1 oe with cs_n high", dq_oe, 1'b0);
      rd_n = 1'b1; cs_n = 1'b0;
      @(negedge clk); chk("R1 oe with rd_n high", dq_oe, 1'b0);
      cs_n = 1'b1;
      hwr(1'b0, 8'h00);
      chk("R1 oe during write", oe, 1'b0);
      l_rd();

      // R3/R4/R2: all input-buffer bytes
      for (int v = 0; v < 256; v++) begin
         hwr(v[0], v[7:0]);
         m_ibf = 1; m_cmd = v[0]; m_ibuf = v[7:0];
         chk("R3 input buffer byte", loc_ibuf_q, m_ibuf);
         hrd(1'b1);
         chk("R3 status after host write", q, exp_sts());
         l_rd();
         m_ibf = 0;
         hrd(1'b1);
         chk("R4 status after local consume", q, exp_sts());
      end

      // R5/R2: all output-buffer bytes
      for (int v = 0; v < 256; v++) begin
         l_obuf(v[7:0]);
         m_obf = 1;
         hrd(1'b1);
         chk("R5 obf set after local write", q, exp_sts());
         hrd(1'b1);
         chk("R5 status read keeps obf", q, exp_sts());
         hrd(1'b0);
         chk("R2 data read returns output buffer", q, v[7:0]);
         m_obf = 0;
         hrd(1'b1);
         chk("R5 obf cleared by data read", q, exp_sts());
      end

      // R6/R11: status nibble and user flag with nonzero low bits
      hwr(1'b1, 8'h96);
      m_ibf = 1; m_cmd = 1; m_ibuf = 8'h96;
      l_obuf(8'h42); m_obf = 1;
      for (int v = 0; v < 32; v++) begin
         loc_uflag = v[4];
         l_sts({v[3:0], ~v[3:0]});
         m_hi = v[3:0];
         hrd(1'b1);
         chk("R6 R11 status nibble and user flag", q, exp_sts());
      end
      chk("R6 input buffer untouched", loc_ibuf_q, 8'h96);
      loc_uflag = 0;

      // R7: pin routing with two flag states
      pin_sweep("R7 pins obf ibf set");
      l_rd(); m_ibf = 0;
      hrd(1'b0); m_obf = 0;
      pin_sweep("R7 pins flags clear");
      cfg_obf_pin = 1; cfg_ibf_pin = 1; cfg_dma_en = 1; port_d = 3'b000;

      // R4: consume pulse coincident with the host write update
      host_cyc(1'b1, 1'b0, 1'b0, 8'h5A, SYNC, q, oe);
      m_ibf = 1; m_cmd = 0;
      hrd(1'b1);
      chk("R4 same-cycle write keeps ibf", q, exp_sts());
      host_cyc(1'b1, 1'b0, 1'b1, 8'hA5, SYNC + 1, q, oe);
      m_ibf = 0; m_cmd = 1;
      hrd(1'b1);
      chk("R4 consume one cycle later clears ibf", q, exp_sts());
      chk("R3 byte from race write", loc_ibuf_q, 8'hA5);

      // R8/R9: DMA enabled
      l_drq(); m_drq = 1;
      chk("R9 request on pin", port_q[2], 1'b1);
      host_cyc(1'b1, 1'b1, 1'b1, 8'h3C, 0, q, oe);
      m_drq = 0; m_ibf = 1; m_cmd = 0;
      chk("R9 request cleared by acknowledge", port_q[2], 1'b0);
      chk("R8 acknowledged write loads buffer", loc_ibuf_q, 8'h3C);
      hrd(1'b1);
      chk("R8 acknowledged write tagged as data", q, exp_sts());
      l_obuf(8'hC3); m_obf = 1;
      host_cyc(1'b0, 1'b1, 1'b1, 8'h00, 0, q, oe);
      chk("R8 acknowledged read returns output buffer", q, 8'hC3);
      chk("R8 acknowledged read drives bus", oe, 1'b1);
      m_obf = 0;
      hrd(1'b1);
      chk("R8 acknowledged read clears obf", q, exp_sts());

      // R8/R9: DMA disabled, acknowledge ignored
      cfg_dma_en = 0;
      l_drq(); m_drq = 1;
      l_obuf(8'h11); m_obf = 1;
      host_cyc(1'b1, 1'b1, 1'b0, 8'h77, 0, q, oe);
      chk("R8 ignored acknowledge write", loc_ibuf_q, 8'h3C);
      host_cyc(1'b0, 1'b1, 1'b0, 8'h00, 0, q, oe);
      chk("R8 ignored acknowledge read no drive", oe, 1'b0);
      hrd(1'b1);
      chk("R8 status unchanged without DMA", q, exp_sts());
      hrd(1'b0); m_obf = 0;
      chk("R8 output buffer kept", q, 8'h11);
      @(negedge clk); cfg_dma_en = 1;
      @(negedge clk);
      chk("R9 request survives ignored acknowledge", port_q[2], m_drq);

      // R10: reset during operation
      hwr(1'b1, 8'hEE);
      l_obuf(8'hDD);
      l_sts(8'hF0);
      do_reset();
      hrd(1'b1);
      chk("R10 status after mid-run reset", q, 8'h00);
      chk("R10 ibuf after mid-run reset", loc_ibuf_q, 8'h00);
      chk("R10 pins after mid-run reset", port_q, 3'b000);
      hrd(1'b0);
      chk("R10 obuf after mid-run reset", q, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule